// File: doc/BRIEF.md
# Supply Supervisor Operating-Mode Sequencer

This block decides which operating mode a power-supervision chip is in and what that mode switches on. Software asks for a mode by pulsing a write strobe together with a 3-bit mode code. Faults detected elsewhere on the chip arrive as single-cycle pulses and can override the request: thermal shutdown, main-supply short, main-supply over-voltage, main-supply under-voltage and watchdog failure. Wake pulses from the bus transceivers or local pins also arrive as single-cycle pulses. From the current mode and any configuration frozen from Normal, the block drives a reset request, enables for both supplies, the watchdog (with a long-window flag), the transceivers, their wake-capable state and the high-side switches. It also drives a fault indication and reports the current mode.

Severe faults end in a Fail-Safe mode. Fail-Safe cannot be left until a dwell time, counted in 1 kHz ticks, has elapsed. The dwell is longer when the entry was thermal. A wake that arrives while the dwell is still running is remembered and honoured as soon as the dwell ends. Lighter faults pass through a Restart mode that holds reset for a fixed number of cycles and then returns to Normal by itself. Repeat counters for under-voltage and watchdog failures decide whether a fault escalates to Fail-Safe. A build-time variant for development boards stops the watchdog and keeps the second supply and the transceivers powered from Init onwards.

Top module: `sbc_mode_ctrl`

## Requirements
- R1: After reset the mode is Init (code 0). Main supply is on. Watchdog is on with its long window. Second supply, transceivers, high-side switches, fault and reset request are off.
- R2: In Init, any software write with no fault present moves the mode to Normal (code 1) on the next cycle, whatever the written code.
- R3: Mode codes are 0 Init, 1 Normal, 2 Stop, 3 Sleep, 4 Restart, 5 Fail-Safe, and the mode output never shows any other value. In Normal, writes of 2, 3 or 4 go to Stop, Sleep or Restart, and a write of 1 stays in Normal. In Stop, a write of 1 returns to Normal and a write of 3 goes to Sleep. Every other code is ignored, and Sleep, Restart and Fail-Safe ignore writes.
- R4: Restart raises the reset request and turns off the watchdog, second supply and high-side switches. It lasts RST_CYCLES cycles and then enters Normal. There the long-window flag stays high until the first write is accepted in Normal. The reset request is low in Init, Normal, Stop and Sleep.
- R5: A watchdog failure in Init, Normal or Stop goes to Fail-Safe when the watchdog code is 2. With code 4 the first failure goes to Restart and the second goes to Fail-Safe. With any other code a failure goes to Restart.
- R6: A main-supply over-voltage is ignored while the over-voltage option is off. With the option on, it goes to Fail-Safe under watchdog codes 2 and 4, and to Restart under any other code.
- R7: A main-supply under-voltage in Init, Normal or Stop goes to Restart. The UV_LIMIT-th consecutive one goes to Fail-Safe instead, but only while the battery-good input is high. The repeat counters are cleared by a write accepted in Init or Normal, and on Fail-Safe entry.
- R8: A thermal shutdown or supply short in any mode other than Fail-Safe enters Fail-Safe on the next cycle. Fail-Safe turns off both supplies, the watchdog and the high-side switches, and raises the fault output and the reset request.
- R9: Fail-Safe holds for at least DWELL_LONG ticks after a thermal entry and DWELL_SHORT ticks after any other entry. A wake seen during the dwell is stored. When the dwell has ended and a wake is present or stored, the mode goes to Restart.
- R10: Sleep turns off the main supply and the watchdog, puts the transceivers in the wake-capable state, and leaves on a wake to Restart. Stop and Sleep keep the second supply, transceiver and high-side settings as they were in Normal. The configuration input is cfg_i[0] second supply, cfg_i[1] transceivers, cfg_i[2] high-side.
- R11: Events arriving in the same cycle are resolved in this order: thermal shutdown, supply short, over-voltage, under-voltage, watchdog failure, wake, software write.
- R12: With DEV_VARIANT set, the watchdog is off and its failures are ignored, and the second supply and the transceivers are on in Init and stay on in Normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Software mode write strobe |
| req_mode_i | input | 3 | Requested mode code |
| cfg_i | input | 3 | Normal-mode settings: [0] second supply, [1] transceivers, [2] high-side |
| wd_cfg_i | input | 3 | Watchdog failure configuration code |
| ov_rst_en_i | input | 1 | Enables action on over-voltage |
| vs_ok_i | input | 1 | Battery above its under-voltage threshold |
| tsd_i | input | 1 | Thermal shutdown pulse |
| short_i | input | 1 | Main-supply short pulse |
| ov_i | input | 1 | Main-supply over-voltage pulse |
| uv_i | input | 1 | Main-supply under-voltage pulse |
| wd_fail_i | input | 1 | Watchdog failure pulse |
| wake_i | input | 1 | Wake pulse from bus or local pin |
| tick_i | input | 1 | 1 kHz dwell tick |
| mode_o | output | 3 | Current mode code |
| rst_o | output | 1 | Reset request |
| en_vcc1_o | output | 1 | Main supply enable |
| en_vcc2_o | output | 1 | Second supply enable |
| en_wd_o | output | 1 | Watchdog enable |
| wd_long_o | output | 1 | Watchdog long open window |
| en_xcvr_o | output | 1 | Transceivers active |
| xcvr_wake_o | output | 1 | Transceivers wake-capable |
| en_hs_o | output | 1 | High-side switches enable |
| fault_o | output | 1 | Fault outputs active |

## Verification
The bench counts down the dwell and looks for an early exit: a wake that arrives mid-dwell must be held and must fire exactly one cycle after the last tick. A design that dropped the stored wake would sit in Fail-Safe forever, and one that used the short dwell for a thermal entry would leave three ticks early. The escalation counters are checked for their clearing rules. Under-voltage repeats with a low battery input must keep going to Restart, and after a software write the next under-voltage must go to Restart again, not to Fail-Safe. Same-cycle fault pairs check that thermal beats short and that under-voltage beats watchdog failure under code 2; a wrong order would show a short dwell or an immediate Fail-Safe.

// File: rtl/sbc_mode_pkg.sv
`timescale 1ns/1ps
package sbc_mode_pkg;
  typedef enum logic [2:0] {
    M_INIT     = 3'd0,
    M_NORMAL   = 3'd1,
    M_STOP     = 3'd2,
    M_SLEEP    = 3'd3,
    M_RESTART  = 3'd4,
    M_FAILSAFE = 3'd5
  } mode_e;

  localparam logic [2:0] REQ_NORMAL  = 3'd1;
  localparam logic [2:0] REQ_STOP    = 3'd2;
  localparam logic [2:0] REQ_SLEEP   = 3'd3;
  localparam logic [2:0] REQ_RESTART = 3'd4;

  typedef struct packed {
    logic hs;
    logic xcvr;
    logic vcc2;
  } cfg_t;
endpackage

// File: rtl/sbc_evt_arb.sv
`timescale 1ns/1ps
module sbc_evt_arb
  import sbc_mode_pkg::*;
#(
  parameter int UV_LIMIT    = 4,
  parameter int DEV_VARIANT = 0,
  localparam int UV_CW      = (UV_LIMIT > 2) ? $clog2(UV_LIMIT) : 1
) (
  input  mode_e            mode_i,
  input  logic             tsd_i,
  input  logic             short_i,
  input  logic             ov_i,
  input  logic             ov_rst_en_i,
  input  logic             uv_i,
  input  logic             vs_ok_i,
  input  logic [UV_CW-1:0] uv_cnt_i,
  input  logic             wd_fail_i,
  input  logic [2:0]       wd_cfg_i,
  input  logic             wd_seen_i,
  input  logic             wake_i,
  input  logic             wake_pend_i,
  input  logic             dwell_done_i,
  input  logic             rst_done_i,
  input  logic             req_valid_i,
  input  logic [2:0]       req_mode_i,
  output mode_e            nxt_o,
  output logic             fs_long_o,
  output logic             uv_inc_o,
  output logic             wd_inc_o,
  output logic             req_acc_o
);
  localparam logic WD_ON = (DEV_VARIANT == 0);
  localparam logic [UV_CW-1:0] UV_LAST = UV_CW'(UV_LIMIT - 1);

  logic supply_up, fs_code;
  assign supply_up = (mode_i == M_INIT) || (mode_i == M_NORMAL) || (mode_i == M_STOP);
  assign fs_code   = (wd_cfg_i == 3'd2) || (wd_cfg_i == 3'd4);

  always_comb begin
    nxt_o     = mode_i;
    fs_long_o = 1'b0;
    uv_inc_o  = 1'b0;
    wd_inc_o  = 1'b0;
    req_acc_o = 1'b0;
    if (mode_i == M_FAILSAFE) begin
      if (dwell_done_i && (wake_i || wake_pend_i)) nxt_o = M_RESTART;
    end else if (tsd_i) begin
      nxt_o     = M_FAILSAFE;
      fs_long_o = 1'b1;
    end else if (short_i) begin
      nxt_o = M_FAILSAFE;
    end else if (ov_i && ov_rst_en_i && supply_up) begin
      nxt_o = fs_code ? M_FAILSAFE : M_RESTART;
    end else if (uv_i && supply_up) begin
      uv_inc_o = 1'b1;
      nxt_o    = (uv_cnt_i == UV_LAST && vs_ok_i) ? M_FAILSAFE : M_RESTART;
    end else if (wd_fail_i && WD_ON && supply_up) begin
      wd_inc_o = 1'b1;
      if (wd_cfg_i == 3'd2 || (wd_cfg_i == 3'd4 && wd_seen_i)) nxt_o = M_FAILSAFE;
      else                                                      nxt_o = M_RESTART;
    end else if (mode_i == M_RESTART) begin
      if (rst_done_i) nxt_o = M_NORMAL;
    end else if (mode_i == M_SLEEP) begin
      if (wake_i) nxt_o = M_RESTART;
    end else if (req_valid_i) begin
      unique case (mode_i)
        M_INIT: begin
          nxt_o     = M_NORMAL;
          req_acc_o = 1'b1;
        end
        M_NORMAL: begin
          req_acc_o = (req_mode_i == REQ_NORMAL) || (req_mode_i == REQ_STOP) ||
                      (req_mode_i == REQ_SLEEP)  || (req_mode_i == REQ_RESTART);
          if (req_mode_i == REQ_STOP)         nxt_o = M_STOP;
          else if (req_mode_i == REQ_SLEEP)   nxt_o = M_SLEEP;
          else if (req_mode_i == REQ_RESTART) nxt_o = M_RESTART;
        end
        M_STOP: begin
          req_acc_o = (req_mode_i == REQ_NORMAL) || (req_mode_i == REQ_SLEEP);
          if (req_mode_i == REQ_NORMAL)      nxt_o = M_NORMAL;
          else if (req_mode_i == REQ_SLEEP)  nxt_o = M_SLEEP;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sbc_mode_tmr.sv
`timescale 1ns/1ps
module sbc_mode_tmr
  import sbc_mode_pkg::*;
#(
  parameter int DWELL_LONG  = 1000,
  parameter int DWELL_SHORT = 100,
  parameter int RST_CYCLES  = 4,
  localparam int DW_CW      = $clog2(DWELL_LONG + 1),
  localparam int RC_CW      = $clog2(RST_CYCLES + 1)
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  mode_e nxt_i,
  input  logic  fs_long_i,
  input  logic  tick_i,
  input  logic  wake_i,
  output logic  dwell_done_o,
  output logic  wake_pend_o,
  output logic  rst_done_o
);
  localparam logic [DW_CW-1:0] DW_LONG  = DW_CW'(DWELL_LONG);
  localparam logic [DW_CW-1:0] DW_SHORT = DW_CW'(DWELL_SHORT);
  localparam logic [RC_CW-1:0] RC_LOAD  = RC_CW'(RST_CYCLES - 1);

  logic [DW_CW-1:0] dw_q;
  logic [RC_CW-1:0] rc_q;
  logic             wp_q;
  logic             fs_enter, rs_enter, in_fs;

  assign in_fs    = (mode_i == M_FAILSAFE);
  assign fs_enter = (nxt_i == M_FAILSAFE) && !in_fs;
  assign rs_enter = (nxt_i == M_RESTART) && (mode_i != M_RESTART);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dw_q <= '0;
      rc_q <= '0;
      wp_q <= 1'b0;
    end else begin
      if (fs_enter)                        dw_q <= fs_long_i ? DW_LONG : DW_SHORT;
      else if (in_fs && tick_i && dw_q != '0) dw_q <= dw_q - 1'b1;

      if (rs_enter)                                 rc_q <= RC_LOAD;
      else if (mode_i == M_RESTART && rc_q != '0)   rc_q <= rc_q - 1'b1;

      // wake stored only while inside Fail-Safe
      wp_q <= in_fs && (wp_q || wake_i);
    end
  end

  assign dwell_done_o = (dw_q == '0);
  assign wake_pend_o  = wp_q;
  assign rst_done_o   = (rc_q == '0);
endmodule

// File: rtl/sbc_mode_dec.sv
`timescale 1ns/1ps
module sbc_mode_dec
  import sbc_mode_pkg::*;
#(
  parameter int DEV_VARIANT = 0
) (
  input  mode_e mode_i,
  input  cfg_t  cfg_live_i,
  input  cfg_t  cfg_hold_i,
  input  logic  lw_i,
  output logic  rst_o,
  output logic  en_vcc1_o,
  output logic  en_vcc2_o,
  output logic  en_wd_o,
  output logic  wd_long_o,
  output logic  en_xcvr_o,
  output logic  xcvr_wake_o,
  output logic  en_hs_o,
  output logic  fault_o
);
  localparam logic DEV = (DEV_VARIANT != 0);

  logic wd_raw;

  always_comb begin
    rst_o       = 1'b0;
    en_vcc1_o   = 1'b1;
    en_vcc2_o   = 1'b0;
    wd_raw      = 1'b0;
    wd_long_o   = 1'b0;
    en_xcvr_o   = 1'b0;
    xcvr_wake_o = 1'b0;
    en_hs_o     = 1'b0;
    fault_o     = 1'b0;
    unique case (mode_i)
      M_INIT: begin
        wd_raw    = 1'b1;
        wd_long_o = !DEV;
        en_vcc2_o = DEV;
        en_xcvr_o = DEV;
      end
      M_NORMAL: begin
        wd_raw    = 1'b1;
        wd_long_o = lw_i && !DEV;
        en_vcc2_o = cfg_live_i.vcc2 || DEV;
        en_xcvr_o = cfg_live_i.xcvr || DEV;
        en_hs_o   = cfg_live_i.hs;
      end
      M_STOP: begin
        wd_raw    = 1'b1;
        en_vcc2_o = cfg_hold_i.vcc2 || DEV;
        en_xcvr_o = cfg_hold_i.xcvr || DEV;
        en_hs_o   = cfg_hold_i.hs;
      end
      M_SLEEP: begin
        en_vcc1_o   = 1'b0;
        en_vcc2_o   = cfg_hold_i.vcc2 || DEV;
        en_hs_o     = cfg_hold_i.hs;
        xcvr_wake_o = 1'b1;
      end
      M_RESTART: rst_o = 1'b1;
      M_FAILSAFE: begin
        rst_o       = 1'b1;
        en_vcc1_o   = 1'b0;
        xcvr_wake_o = 1'b1;
        fault_o     = 1'b1;
      end
      default: ;
    endcase
    en_wd_o = wd_raw && !DEV;
  end
endmodule

// File: rtl/sbc_mode_ctrl.sv
`timescale 1ns/1ps
module sbc_mode_ctrl
  import sbc_mode_pkg::*;
#(
  parameter int DEV_VARIANT = 0,
  parameter int UV_LIMIT    = 4,
  parameter int DWELL_LONG  = 1000,
  parameter int DWELL_SHORT = 100,
  parameter int RST_CYCLES  = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic [2:0] req_mode_i,
  input  logic [2:0] cfg_i,
  input  logic [2:0] wd_cfg_i,
  input  logic       ov_rst_en_i,
  input  logic       vs_ok_i,
  input  logic       tsd_i,
  input  logic       short_i,
  input  logic       ov_i,
  input  logic       uv_i,
  input  logic       wd_fail_i,
  input  logic       wake_i,
  input  logic       tick_i,
  output logic [2:0] mode_o,
  output logic       rst_o,
  output logic       en_vcc1_o,
  output logic       en_vcc2_o,
  output logic       en_wd_o,
  output logic       wd_long_o,
  output logic       en_xcvr_o,
  output logic       xcvr_wake_o,
  output logic       en_hs_o,
  output logic       fault_o
);
  localparam int UV_CW = (UV_LIMIT > 2) ? $clog2(UV_LIMIT) : 1;
  localparam logic [UV_CW-1:0] UV_LAST = UV_CW'(UV_LIMIT - 1);

  mode_e            mode_q, nxt;
  logic [UV_CW-1:0] uv_cnt_q;
  logic             wd_seen_q, lw_q;
  cfg_t             cfg_q, cfg_live;
  logic             fs_long, uv_inc, wd_inc, req_acc;
  logic             dwell_done, wake_pend, rst_done, cnt_clr;

  assign cfg_live = cfg_t'(cfg_i);

  sbc_evt_arb #(.UV_LIMIT(UV_LIMIT), .DEV_VARIANT(DEV_VARIANT)) u_arb (
    .mode_i(mode_q), .tsd_i, .short_i, .ov_i, .ov_rst_en_i, .uv_i, .vs_ok_i,
    .uv_cnt_i(uv_cnt_q), .wd_fail_i, .wd_cfg_i, .wd_seen_i(wd_seen_q), .wake_i,
    .wake_pend_i(wake_pend), .dwell_done_i(dwell_done), .rst_done_i(rst_done),
    .req_valid_i, .req_mode_i, .nxt_o(nxt), .fs_long_o(fs_long),
    .uv_inc_o(uv_inc), .wd_inc_o(wd_inc), .req_acc_o(req_acc)
  );

  sbc_mode_tmr #(.DWELL_LONG(DWELL_LONG), .DWELL_SHORT(DWELL_SHORT),
                 .RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk_i, .rst_ni, .mode_i(mode_q), .nxt_i(nxt), .fs_long_i(fs_long),
    .tick_i, .wake_i, .dwell_done_o(dwell_done), .wake_pend_o(wake_pend),
    .rst_done_o(rst_done)
  );

  sbc_mode_dec #(.DEV_VARIANT(DEV_VARIANT)) u_dec (
    .mode_i(mode_q), .cfg_live_i(cfg_live), .cfg_hold_i(cfg_q), .lw_i(lw_q),
    .rst_o, .en_vcc1_o, .en_vcc2_o, .en_wd_o, .wd_long_o, .en_xcvr_o,
    .xcvr_wake_o, .en_hs_o, .fault_o
  );

  // software regaining control, or escalation done, restarts the repeat counts
  assign cnt_clr = (req_acc && (mode_q == M_INIT || mode_q == M_NORMAL)) ||
                   (nxt == M_FAILSAFE && mode_q != M_FAILSAFE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= M_INIT;
      uv_cnt_q  <= '0;
      wd_seen_q <= 1'b0;
      lw_q      <= 1'b0;
      cfg_q     <= '0;
    end else begin
      mode_q <= nxt;
      if (cnt_clr) begin
        uv_cnt_q  <= '0;
        wd_seen_q <= 1'b0;
      end else begin
        if (uv_inc && uv_cnt_q != UV_LAST) uv_cnt_q <= uv_cnt_q + 1'b1;
        if (wd_inc)                        wd_seen_q <= 1'b1;
      end
      if (mode_q == M_RESTART && nxt == M_NORMAL)  lw_q <= 1'b1;
      else if (req_acc && mode_q == M_NORMAL)      lw_q <= 1'b0;
      if (mode_q == M_NORMAL) cfg_q <= cfg_live;
    end
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/sbc_mode_chk.sv
`timescale 1ns/1ps
module sbc_mode_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_o,
  input logic       req_valid_i,
  input logic       tsd_i,
  input logic       short_i,
  input logic       ov_i,
  input logic       uv_i,
  input logic       wd_fail_i,
  input logic       wake_i,
  input logic       rst_o,
  input logic       en_vcc1_o,
  input logic       en_vcc2_o,
  input logic       en_wd_o,
  input logic       en_hs_o,
  input logic       fault_o
);
  p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o <= 3'd5);

  p_init_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd0 && req_valid_i && !tsd_i && !short_i && !ov_i && !uv_i && !wd_fail_i)
    |=> mode_o == 3'd1);

  p_restart_out_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd4) |-> (rst_o && !en_wd_o && !en_vcc2_o && !en_hs_o));

  p_no_reset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o <= 3'd3) |-> !rst_o);

  p_failsafe_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |-> (!en_vcc1_o && !en_vcc2_o && !en_wd_o && !en_hs_o && fault_o && rst_o));

  p_thermal_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tsd_i && mode_o != 3'd5) |=> mode_o == 3'd5);

  p_fs_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd4));

  p_sleep_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd3 && wake_i && !tsd_i && !short_i) |=> mode_o == 3'd4);
endmodule

bind sbc_mode_ctrl sbc_mode_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .req_valid_i(req_valid_i),
  .tsd_i(tsd_i), .short_i(short_i), .ov_i(ov_i), .uv_i(uv_i),
  .wd_fail_i(wd_fail_i), .wake_i(wake_i), .rst_o(rst_o), .en_vcc1_o(en_vcc1_o),
  .en_vcc2_o(en_vcc2_o), .en_wd_o(en_wd_o), .en_hs_o(en_hs_o), .fault_o(fault_o)
);

// File: tb/tb_sbc_mode_ctrl.sv
`timescale 1ns/1ps
module tb_sbc_mode_ctrl;
  localparam int DW_L = 5, DW_S = 2, RST_C = 2;
  localparam logic [7:0] E_REQ = 8'd1, E_WAKE = 8'd2, E_WD = 8'd4, E_UV = 8'd8,
                         E_OV = 8'd16, E_SHORT = 8'd32, E_TSD = 8'd64, E_TICK = 8'd128;
  // {expected mode[13:11], request code[10:8], events[7:0]}
  localparam int NV = 21;
  localparam logic [13:0] VEC [NV] = '{
    {3'd1, 3'd0, E_REQ}, {3'd2, 3'd2, E_REQ}, {3'd2, 3'd4, E_REQ}, {3'd1, 3'd1, E_REQ},
    {3'd1, 3'd5, E_REQ}, {3'd4, 3'd4, E_REQ}, {3'd4, 3'd0, 8'd0},  {3'd1, 3'd0, 8'd0},
    {3'd3, 3'd3, E_REQ}, {3'd3, 3'd1, E_REQ}, {3'd3, 3'd0, E_UV},  {3'd4, 3'd0, E_WAKE},
    {3'd4, 3'd0, 8'd0},  {3'd1, 3'd0, 8'd0},  {3'd4, 3'd0, E_WD},  {3'd4, 3'd0, 8'd0},
    {3'd1, 3'd0, 8'd0},  {3'd4, 3'd0, E_OV | E_UV | E_WD}, {3'd4, 3'd0, 8'd0},
    {3'd1, 3'd0, 8'd0},  {3'd1, 3'd1, E_REQ}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, wd_fail = 0, uv = 0, ov = 0, short_f = 0, tsd = 0, wake = 0, tick = 0;
  logic [2:0] req_mode = 0, cfg = 0, wd_cfg = 3'd1;
  logic ov_en = 1'b1, vs_ok = 1'b1;
  logic [2:0] mode, mode_d;
  logic rst_out, vcc1, vcc2, wd_en, wd_long, xcvr, xwake, hs, fault;
  logic rst_out_d, vcc1_d, vcc2_d, wd_en_d, wd_long_d, xcvr_d, xwake_d, hs_d, fault_d;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sbc_mode_ctrl #(.DWELL_LONG(DW_L), .DWELL_SHORT(DW_S), .RST_CYCLES(RST_C)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .cfg_i(cfg), .wd_cfg_i(wd_cfg), .ov_rst_en_i(ov_en), .vs_ok_i(vs_ok),
    .tsd_i(tsd), .short_i(short_f), .ov_i(ov), .uv_i(uv), .wd_fail_i(wd_fail),
    .wake_i(wake), .tick_i(tick), .mode_o(mode), .rst_o(rst_out), .en_vcc1_o(vcc1),
    .en_vcc2_o(vcc2), .en_wd_o(wd_en), .wd_long_o(wd_long), .en_xcvr_o(xcvr),
    .xcvr_wake_o(xwake), .en_hs_o(hs), .fault_o(fault));

  sbc_mode_ctrl #(.DEV_VARIANT(1), .DWELL_LONG(DW_L), .DWELL_SHORT(DW_S),
                  .RST_CYCLES(RST_C)) dut_dev (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .cfg_i(cfg), .wd_cfg_i(wd_cfg), .ov_rst_en_i(ov_en), .vs_ok_i(vs_ok),
    .tsd_i(tsd), .short_i(short_f), .ov_i(ov), .uv_i(uv), .wd_fail_i(wd_fail),
    .wake_i(wake), .tick_i(tick), .mode_o(mode_d), .rst_o(rst_out_d), .en_vcc1_o(vcc1_d),
    .en_vcc2_o(vcc2_d), .en_wd_o(wd_en_d), .wd_long_o(wd_long_d), .en_xcvr_o(xcvr_d),
    .xcvr_wake_o(xwake_d), .en_hs_o(hs_d), .fault_o(fault_d));

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [7:0] ev, input logic [2:0] code);
    @(negedge clk);
    req_valid = ev[0]; wake = ev[1]; wd_fail = ev[2]; uv = ev[3];
    ov = ev[4]; short_f = ev[5]; tsd = ev[6]; tick = ev[7]; req_mode = code;
    @(posedge clk); #1;
    req_valid = 0; wake = 0; wd_fail = 0; uv = 0; ov = 0; short_f = 0; tsd = 0; tick = 0;
  endtask

  task automatic idle2_normal(input string tag);
    step(8'd0, 3'd0); chk(tag, mode, 3'd4);
    step(8'd0, 3'd0); chk(tag, mode, 3'd1);
  endtask

  // leave a short-dwell Fail-Safe and come back to Normal
  task automatic recover(input string tag);
    step(E_TICK, 3'd0); step(E_TICK, 3'd0);
    step(E_WAKE, 3'd0); chk(tag, mode, 3'd4);
    idle2_normal(tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1 mode", mode, 3'd0);
    chk("R1 outputs", {vcc1, wd_en, wd_long}, 3'b111);
    chk("R1 off", {vcc2, xcvr, hs}, 3'b000);
    chk("R1 rst/fault", {rst_out, fault, 1'b0}, 3'b000);
    // R12 development variant in Init
    chk("R12 dev init", {vcc2_d, xcvr_d, wd_en_d}, 3'b110);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][7:0], VEC[i][10:8]);
      chk($sformatf("R3 vector %0d", i), mode, VEC[i][13:11]);
      if (i == 0) chk("R12 dev normal", {vcc2_d, xcvr_d, wd_en_d}, 3'b110);
    end

    // R10 Stop freezes Normal settings, Sleep outputs
    cfg = 3'b111; step(8'd0, 3'd0);
    chk("R10 normal cfg", {hs, xcvr, vcc2}, 3'b111);
    step(E_REQ, 3'd2); cfg = 3'b000; step(8'd0, 3'd0);
    chk("R10 stop frozen", {hs, xcvr, vcc2}, 3'b111);
    step(E_REQ, 3'd3); chk("R10 sleep mode", mode, 3'd3);
    chk("R10 sleep outputs", {vcc1, wd_en, xcvr}, 3'b000);
    chk("R10 sleep held", {xwake, vcc2, hs}, 3'b111);
    step(E_WAKE, 3'd0); chk("R10 wake", mode, 3'd4);
    // R4 Restart outputs and long window afterwards
    chk("R4 restart outputs", {rst_out, vcc1, wd_en}, 3'b110);
    chk("R4 restart off", {vcc2, hs, fault}, 3'b000);
    idle2_normal("R4 return");
    chk("R4 long window", {wd_long, rst_out, 1'b0}, 3'b100);
    step(E_REQ, 3'd1); chk("R4 window closed", {wd_long, 2'b00}, 3'b000);

    // R7 under-voltage repeats
    for (int k = 0; k < 3; k++) begin
      step(E_UV, 3'd0); chk("R7 uv restart", mode, 3'd4);
      idle2_normal("R7");
    end
    step(E_UV, 3'd0); chk("R7 fourth uv", mode, 3'd5);
    chk("R8 failsafe outputs", {vcc1, wd_en, hs}, 3'b000);
    chk("R8 failsafe flags", {fault, rst_out, xwake}, 3'b111);
    recover("R9 recover");
    vs_ok = 1'b0;
    for (int k = 0; k < 4; k++) begin
      step(E_UV, 3'd0); chk("R7 low battery", mode, 3'd4);
      idle2_normal("R7");
    end
    vs_ok = 1'b1;
    step(E_REQ, 3'd1);
    step(E_UV, 3'd0); chk("R7 cleared by write", mode, 3'd4);
    idle2_normal("R7"); step(E_REQ, 3'd1);

    // R5 watchdog codes
    wd_cfg = 3'd4;
    step(E_WD, 3'd0); chk("R5 code4 first", mode, 3'd4); idle2_normal("R5");
    step(E_WD, 3'd0); chk("R5 code4 second", mode, 3'd5); recover("R5");
    wd_cfg = 3'd2;
    step(E_WD, 3'd0); chk("R5 code2 first", mode, 3'd5); recover("R5");
    wd_cfg = 3'd3;
    step(E_WD, 3'd0); chk("R5 code3", mode, 3'd4); idle2_normal("R5");

    // R6 over-voltage
    ov_en = 1'b0; step(E_OV, 3'd0); chk("R6 disabled", mode, 3'd1);
    ov_en = 1'b1; wd_cfg = 3'd4;
    step(E_OV, 3'd0); chk("R6 code4", mode, 3'd5); recover("R6");
    wd_cfg = 3'd3;
    step(E_OV, 3'd0); chk("R6 code3", mode, 3'd4); idle2_normal("R6");

    // R9 thermal dwell with stored wake
    step(E_TSD, 3'd0); chk("R9 tsd entry", mode, 3'd5);
    step(E_WAKE, 3'd0); chk("R9 wake stored", mode, 3'd5);
    for (int k = 0; k < DW_L; k++) begin
      step(E_TICK, 3'd0); chk("R9 long dwell", mode, 3'd5);
    end
    step(8'd0, 3'd0); chk("R9 stored wake fires", mode, 3'd4);
    idle2_normal("R9");
    // R9 short dwell: no exit without wake, early wake held
    step(E_SHORT, 3'd0); chk("R9 short entry", mode, 3'd5);
    step(E_TICK, 3'd0); step(E_TICK, 3'd0);
    step(8'd0, 3'd0); step(8'd0, 3'd0); chk("R9 no wake stays", mode, 3'd5);
    step(E_WAKE, 3'd0); chk("R9 wake after dwell", mode, 3'd4);
    idle2_normal("R9");

    // R11 priority: thermal over short gives long dwell
    step(E_TSD | E_SHORT | E_WAKE | E_REQ, 3'd2); chk("R11 tsd wins", mode, 3'd5);
    step(E_TICK, 3'd0); step(E_TICK, 3'd0);
    step(E_WAKE, 3'd0); chk("R11 long dwell used", mode, 3'd5);
    for (int k = 0; k < DW_L - DW_S; k++) step(E_TICK, 3'd0);
    chk("R11 dwell end", mode, 3'd5);
    step(8'd0, 3'd0); chk("R11 exit", mode, 3'd4);
    idle2_normal("R11");
    // R11 under-voltage over watchdog code 2
    wd_cfg = 3'd2;
    step(E_UV | E_WD, 3'd0); chk("R11 uv over wd", mode, 3'd4);
    idle2_normal("R11"); step(E_REQ, 3'd1);

    // R1 reset mid-operation
    step(E_REQ, 3'd2);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1 async reset", mode, 3'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule